// File: doc/BRIEF.md
# Sized External Bus Master

This block sits between a processor's load/store path and an asynchronous external bus. It accepts one request at a time: an address, a read or write flag, an access size of one, two or four bytes, and 32-bit write data. It picks one of eight chip selects by comparing the top address bits against a base and mask pair for each select. It then runs the access on the external bus and returns a one-cycle response that carries read data or an error flag.

Each chip select has a port width of 8, 16 or 32 bits. An access wider than the selected port is split into back-to-back beats at increasing addresses. Read bytes from those beats are gathered into a right-justified, big-endian result. Every beat opens with a one-clock transfer start. It closes when the slave pulls the acknowledge or the error line low. An error aborts any beats that remain. The width of chip select 0 comes from two strap pins, so boot code can be fetched before any register is written.

Top module: `ebus_master`

## Requirements
- R1: While reset is applied and in the first cycle after it, every chip select, transfer start, transfer-in-progress, output enable and byte strobe output is high (inactive), `req_ready` is 1 and `rsp_valid` is 0.
- R2: Select i matches when it is enabled and `((req_addr[31:16] ^ base_i) & mask_i) == 0`. The lowest-numbered matching select wins. After reset only select 0 is enabled, with base 0 and mask 0, so it matches every address. Exactly one `bus_cs_n` bit is low for the whole access.
- R3: An accepted request that matches no select produces `rsp_valid=1` with `rsp_err=1` in the next cycle. No chip select and no transfer start is driven for it.
- R4: Width codes are 2'b00 = 32-bit, 2'b01 = 8-bit, 2'b10 = 16-bit and 2'b11 = 32-bit. `req_size` codes are 0 = byte, 1 = halfword and 2 or 3 = word. Select 0 takes its width from `strap_width`, sampled while `rst_n` is low. A configuration write to select 0 ignores `cfg_width`.
- R5: An access of n bytes to a port of p bytes runs max(1, n/p) beats. Address bits below the access size are treated as zero. Beat k drives `bus_addr` = aligned address + k*min(n,p).
- R6: `bus_be_n` is active low. Bit 3 is lane `[31:24]` and bit 0 is lane `[7:0]`. The byte at address A on a p-byte port uses lane 3-(A mod p). Only the lanes the beat uses are low, on reads and on writes. All strobes are high between transfers.
- R7: Write data is right-justified in `req_wdata`, with the lowest-addressed byte most significant. Each byte is driven on its lane of `bus_dout`.
- R8: Read bytes are taken from their lanes at acknowledge and packed into `rsp_rdata` with the same ordering. Unused upper bits are zero.
- R9: `bus_ts_n` is low for exactly one clock at the start of each beat. `bus_tip_n` and the chip select stay low from the first beat's start through the final acknowledge, including between beats.
- R10: `bus_rw` is 1 for a read and 0 for a write, and it is constant through the access. `bus_oe_n` is low only on read beats, from the clock after transfer start until the clock in which acknowledge or error is seen.
- R11: Acknowledge and error are sampled only in the clocks after a beat's transfer start, and a level in the transfer-start clock is ignored. After an acknowledge, the next beat's start follows in the next clock. After the final acknowledge, `rsp_valid` rises and `bus_tip_n` goes high in the next clock.
- R12: An error on any beat ends the access in the next clock with `rsp_err=1`, and no further beats are run. If error and acknowledge are both low, error takes precedence.
- R13: `req_ready` is 1 only when no access is in progress. A request presented while it is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_width | input | 2 | Boot width code for select 0, sampled in reset |
| cfg_we | input | 1 | Write one select's configuration |
| cfg_idx | input | 3 | Select being written |
| cfg_en | input | 1 | Enable for that select |
| cfg_base | input | 16 | Base tag compared with address bits 31:16 |
| cfg_mask | input | 16 | Tag bits that take part in the compare |
| cfg_width | input | 2 | Port width code (ignored for select 0) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 for write |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an error |
| rsp_rdata | output | 32 | Packed read data |
| bus_cs_n | output | 8 | Chip selects, active low |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_tip_n | output | 1 | Transfer in progress, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_be_n | output | 4 | Byte strobes, active low |
| bus_addr | output | 32 | Beat address |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| bus_tea_n | input | 1 | Transfer error, active low |

## Verification
A corrupted beat counter or latched width shows up as the wrong number of transfer-start pulses and as byte addresses off their lanes. It appears on the very next beat, and it stays visible until the response, which comes early or late against the summed slave latencies. A corrupted state register shows up as transfer start lasting more than one clock, output enable during a write or during the start clock, or the in-progress signal staying low after the response. These are seen within one clock. A wrong decode shows up as the wrong chip select at the first transfer start, or as a response with no bus activity.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} ebus_st_e;

  // bytes in a port of the given width code
  function automatic int port_bytes(input logic [1:0] wcode);
    case (wcode)
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 4;
    endcase
  endfunction

  // bytes moved by a request of the given size code
  function automatic int size_bytes(input logic [1:0] scode);
    case (scode)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int beat_total(input logic [1:0] scode, input logic [1:0] wcode);
    int n, p;
    n = size_bytes(scode);
    p = port_bytes(wcode);
    return (n > p) ? n / p : 1;
  endfunction

  // bytes moved per beat
  function automatic int beat_span(input logic [1:0] scode, input logic [1:0] wcode);
    int n, p;
    n = size_bytes(scode);
    p = port_bytes(wcode);
    return (n < p) ? n : p;
  endfunction

  function automatic bit byte_in_beat(input int j, input int k, input int n, input int m);
    return (j < n) && (j >= k * m) && (j < k * m + m);
  endfunction

  function automatic int lane_of(input logic [1:0] alo, input int j, input int p);
    return 3 - ((int'(alo) + j) & (p - 1));
  endfunction

  function automatic logic [3:0] beat_lanes(input logic [1:0] alo, input logic [1:0] scode,
                                            input logic [1:0] wcode, input int k);
    logic [3:0] be;
    int n, p, m;
    be = '0;
    n  = size_bytes(scode);
    p  = port_bytes(wcode);
    m  = beat_span(scode, wcode);
    for (int j = 0; j < 4; j++)
      if (byte_in_beat(j, k, n, m)) be[lane_of(alo, j, p)] = 1'b1;
    return be;
  endfunction

  function automatic logic [31:0] beat_wdata(input logic [1:0] alo, input logic [1:0] scode,
                                             input logic [1:0] wcode, input int k,
                                             input logic [31:0] wd);
    logic [31:0] d;
    int n, p, m;
    d = '0;
    n = size_bytes(scode);
    p = port_bytes(wcode);
    m = beat_span(scode, wcode);
    for (int j = 0; j < 4; j++)
      if (byte_in_beat(j, k, n, m)) d[lane_of(alo, j, p)*8 +: 8] = wd[(n-1-j)*8 +: 8];
    return d;
  endfunction

  function automatic logic [31:0] beat_rmerge(input logic [31:0] acc, input logic [31:0] din,
                                              input logic [1:0] alo, input logic [1:0] scode,
                                              input logic [1:0] wcode, input int k);
    logic [31:0] r;
    int n, p, m;
    r = acc;
    n = size_bytes(scode);
    p = port_bytes(wcode);
    m = beat_span(scode, wcode);
    for (int j = 0; j < 4; j++)
      if (byte_in_beat(j, k, n, m)) r[(n-1-j)*8 +: 8] = din[lane_of(alo, j, p)*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/ebus_cs_decode.sv
module ebus_cs_decode #(
  parameter int N_CS  = 8,
  parameter int TAG_W = 16,
  localparam int IDX_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_width,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [TAG_W-1:0] cfg_base,
  input  logic [TAG_W-1:0] cfg_mask,
  input  logic [1:0]       cfg_width,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [1:0]       hit_width
);

  logic [N_CS-1:0] match;
  logic [1:0]      width_eff [N_CS];
  logic [1:0]      boot_w;

  // strap is sampled on every clock while reset is held
  always_ff @(posedge clk)
    if (!rst_n) boot_w <= strap_width;

  for (genvar i = 0; i < N_CS; i++) begin : g_cs
    logic             en_r;
    logic [TAG_W-1:0] base_r, mask_r;
    logic             wr_this;
    assign wr_this = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en_r   <= (i == 0);
        base_r <= '0;
        mask_r <= '0;
      end else if (wr_this) begin
        en_r   <= cfg_en;
        base_r <= cfg_base;
        mask_r <= cfg_mask;
      end

    if (i == 0) begin : g_boot
      assign width_eff[i] = boot_w;
    end else begin : g_prog
      logic [1:0] width_r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       width_r <= 2'b00;
        else if (wr_this) width_r <= cfg_width;
      assign width_eff[i] = width_r;
    end

    assign match[i] = en_r && (((lk_tag ^ base_r) & mask_r) == '0);
  end

  // lowest index wins
  always_comb begin
    hit_idx   = '0;
    hit_width = 2'b00;
    for (int i = N_CS - 1; i >= 0; i--)
      if (match[i]) begin
        hit_idx   = IDX_W'(i);
        hit_width = width_eff[i];
      end
  end

  assign hit = |match;

endmodule

// File: rtl/ebus_beat_seq.sv
module ebus_beat_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              dec_hit,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic [1:0]        dec_width,
  input  logic              ta_n,
  input  logic              tea_n,
  input  logic [31:0]       din,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output ebus_st_e          st,
  output logic [1:0]        beat_k,
  output logic [ADDR_W-1:0] base_addr,
  output logic [1:0]        cur_size,
  output logic [1:0]        cur_width,
  output logic              cur_we,
  output logic [31:0]       cur_wdata,
  output logic [IDX_W-1:0]  cur_cs,
  output logic              beat_ack,
  output logic              beat_err,
  output logic              last_beat
);

  logic [31:0] acc;
  logic [31:0] acc_next;
  logic        accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat_err  = (st == ST_WAIT) && !tea_n;
  assign beat_ack  = (st == ST_WAIT) && !ta_n && tea_n;
  assign last_beat = (int'(beat_k) == beat_total(cur_size, cur_width) - 1);
  assign acc_next  = cur_we ? acc
                   : beat_rmerge(acc, din, base_addr[1:0], cur_size, cur_width, int'(beat_k));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ST_IDLE;
      beat_k    <= '0;
      base_addr <= '0;
      cur_size  <= '0;
      cur_width <= '0;
      cur_we    <= 1'b0;
      cur_wdata <= '0;
      cur_cs    <= '0;
      acc       <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (!dec_hit) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            base_addr <= req_addr & ~ADDR_W'(size_bytes(req_size) - 1);
            cur_size  <= req_size;
            cur_width <= dec_width;
            cur_we    <= req_we;
            cur_wdata <= req_wdata;
            cur_cs    <= dec_idx;
            beat_k    <= '0;
            acc       <= '0;
            st        <= ST_START;
          end
        end
        ST_START: st <= ST_WAIT;
        ST_WAIT: begin
          if (beat_err) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            st        <= ST_IDLE;
          end else if (beat_ack) begin
            if (last_beat) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_rdata <= acc_next;
              st        <= ST_IDLE;
            end else begin
              acc    <= acc_next;
              beat_k <= beat_k + 2'd1;
              st     <= ST_START;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end

endmodule

// File: rtl/ebus_pin_drive.sv
module ebus_pin_drive
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_CS   = 8,
  parameter int IDX_W  = 3
) (
  input  ebus_st_e          st,
  input  logic [1:0]        beat_k,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        cur_size,
  input  logic [1:0]        cur_width,
  input  logic              cur_we,
  input  logic [31:0]       cur_wdata,
  input  logic [IDX_W-1:0]  cur_cs,
  output logic [N_CS-1:0]   bus_cs_n,
  output logic              bus_ts_n,
  output logic              bus_tip_n,
  output logic              bus_rw,
  output logic              bus_oe_n,
  output logic [3:0]        bus_be_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_dout
);

  logic busy;
  int   step;

  assign busy = (st != ST_IDLE);
  assign step = int'(beat_k) * beat_span(cur_size, cur_width);

  assign bus_cs_n  = busy ? ~(N_CS'(1) << cur_cs) : '1;
  assign bus_ts_n  = (st != ST_START);
  assign bus_tip_n = !busy;
  assign bus_rw    = busy ? !cur_we : 1'b1;
  assign bus_oe_n  = !((st == ST_WAIT) && !cur_we);
  assign bus_be_n  = busy ? ~beat_lanes(base_addr[1:0], cur_size, cur_width, int'(beat_k)) : 4'hF;
  assign bus_addr  = base_addr + ADDR_W'(step);
  assign bus_dout  = (busy && cur_we)
                   ? beat_wdata(base_addr[1:0], cur_size, cur_width, int'(beat_k), cur_wdata) : '0;

endmodule

// File: rtl/ebus_master.sv
module ebus_master
  import ebus_pkg::*;
#(
  parameter int N_CS   = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 16,
  localparam int IDX_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_width,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [TAG_W-1:0]  cfg_base,
  input  logic [TAG_W-1:0]  cfg_mask,
  input  logic [1:0]        cfg_width,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [N_CS-1:0]   bus_cs_n,
  output logic              bus_ts_n,
  output logic              bus_tip_n,
  output logic              bus_rw,
  output logic              bus_oe_n,
  output logic [3:0]        bus_be_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic              bus_ta_n,
  input  logic              bus_tea_n
);

  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [1:0]        dec_width;
  ebus_st_e          st;
  logic [1:0]        beat_k;
  logic [ADDR_W-1:0] base_addr;
  logic [1:0]        cur_size, cur_width;
  logic              cur_we;
  logic [31:0]       cur_wdata;
  logic [IDX_W-1:0]  cur_cs;
  // events brought out for the checker
  logic              beat_ack, beat_err, last_beat;

  ebus_cs_decode #(.N_CS(N_CS), .TAG_W(TAG_W)) u_dec (
    .clk, .rst_n, .strap_width, .cfg_we, .cfg_idx, .cfg_en, .cfg_base, .cfg_mask, .cfg_width,
    .lk_tag   (req_addr[ADDR_W-1 -: TAG_W]),
    .hit      (dec_hit),
    .hit_idx  (dec_idx),
    .hit_width(dec_width)
  );

  ebus_beat_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk, .rst_n, .req_valid, .req_addr, .req_we, .req_size, .req_wdata,
    .dec_hit, .dec_idx, .dec_width,
    .ta_n(bus_ta_n), .tea_n(bus_tea_n), .din(bus_din),
    .req_ready, .rsp_valid, .rsp_err, .rsp_rdata,
    .st, .beat_k, .base_addr, .cur_size, .cur_width, .cur_we, .cur_wdata, .cur_cs,
    .beat_ack, .beat_err, .last_beat
  );

  ebus_pin_drive #(.ADDR_W(ADDR_W), .N_CS(N_CS), .IDX_W(IDX_W)) u_pins (
    .st, .beat_k, .base_addr, .cur_size, .cur_width, .cur_we, .cur_wdata, .cur_cs,
    .bus_cs_n, .bus_ts_n, .bus_tip_n, .bus_rw, .bus_oe_n, .bus_be_n, .bus_addr, .bus_dout
  );

endmodule

// File: rtl/ebus_master_chk.sv
module ebus_master_chk #(
  parameter int N_CS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [N_CS-1:0] bus_cs_n,
  input logic            bus_ts_n,
  input logic            bus_tip_n,
  input logic            bus_rw,
  input logic            bus_oe_n,
  input logic [3:0]      bus_be_n,
  input logic            beat_ack,
  input logic            beat_err,
  input logic            last_beat
);

  assert_ts_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ts_n |=> bus_ts_n);

  assert_ts_in_tip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ts_n |-> !bus_tip_n);

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n) && (!bus_tip_n || (&bus_cs_n)));

  assert_oe_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_rw && bus_ts_n && !bus_tip_n));

  assert_rw_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_tip_n && !$past(bus_tip_n)) |-> $stable(bus_rw));

  assert_be_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tip_n |-> (&bus_be_n));

  assert_be_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_tip_n |-> ($countones(~bus_be_n) >= 1));

  assert_rsp_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && last_beat) |=> (rsp_valid && !rsp_err && bus_tip_n));

  assert_err_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    beat_err |=> (rsp_valid && rsp_err && bus_tip_n && bus_ts_n));

  assert_ready_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_tip_n |-> !req_ready);

endmodule

bind ebus_master ebus_master_chk #(.N_CS(N_CS)) u_chk (
  .clk, .rst_n, .req_ready, .rsp_valid, .rsp_err, .bus_cs_n, .bus_ts_n, .bus_tip_n,
  .bus_rw, .bus_oe_n, .bus_be_n, .beat_ack, .beat_err, .last_beat
);

// File: tb/ebus_master_tb.sv
module ebus_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_width = 2'b10;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [15:0] cfg_base = '0, cfg_mask = '0;
  logic [1:0]  cfg_width = '0;
  logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [7:0]  bus_cs_n;
  logic        bus_ts_n, bus_tip_n, bus_rw, bus_oe_n;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_addr, bus_dout;
  logic [31:0] bus_din = '0;
  logic        bus_ta_n = 1'b1, bus_tea_n = 1'b1;

  always #5 clk = ~clk;

  ebus_master dut_i (.*);

  int n_total = 0, n_pass = 0;
  bit done = 1'b0;
  bit boot_phase = 1'b1;

  // slave / monitor state
  int ts_cnt, tip_cyc, lat_sum, wait_cnt, cur_beat, err_beat, log_n;
  int oe_bad, rw_bad, cs_bad;
  bit glitch, exp_read;
  int exp_p;
  logic [7:0]  exp_cs_pat;
  logic [31:0] log_a [8];
  logic [7:0]  log_d [8];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int pw_bytes(input logic [1:0] w);
    return (w == 2'b01) ? 1 : (w == 2'b10) ? 2 : 4;
  endfunction

  function automatic int sz_bytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  // bench view of the decode as configured: returns -1 for a miss
  function automatic int exp_sel(input logic [31:0] a, output logic [1:0] w);
    w = 2'b10;
    if (boot_phase) return 0;
    case (a[31:28])
      4'h0: begin w = 2'b10; return 0; end
      4'h1: begin w = 2'b01; return 1; end
      4'h2: begin w = 2'b10; return 2; end
      4'h3: begin w = 2'b00; return 3; end
      default: return -1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_tip_n) tip_cyc++;
      if (!bus_oe_n && (!exp_read || !bus_ts_n)) oe_bad++;
      if (exp_read && !bus_tip_n && bus_ts_n && bus_oe_n) oe_bad++;
      if (exp_cs_pat == 8'hFF && (bus_cs_n != 8'hFF || !bus_ts_n)) cs_bad++;
      if (!bus_ts_n) begin
        logic [31:0] pbase;
        int lat;
        ts_cnt++;
        cur_beat = ts_cnt - 1;
        if (bus_cs_n != exp_cs_pat) cs_bad++;
        if (bus_rw != exp_read) rw_bad++;
        pbase = bus_addr & ~32'(exp_p - 1);
        for (int l = 3; l >= 0; l--) begin
          bus_din[l*8 +: 8] = mem_byte(pbase + 32'(3 - l));
          if (!bus_be_n[l] && log_n < 8) begin
            log_a[log_n] = pbase + 32'(3 - l);
            log_d[log_n] = bus_dout[l*8 +: 8];
            log_n++;
          end
        end
        lat = glitch ? 1 + $urandom_range(0, 1) : $urandom_range(0, 2);
        wait_cnt = lat;
        lat_sum += 2 + lat;
        bus_ta_n  = glitch ? 1'b0 : 1'b1;
        bus_tea_n = 1'b1;
      end else if (!bus_tip_n) begin
        if (wait_cnt == 0) begin
          if (cur_beat == err_beat) bus_tea_n = 1'b0;
          else bus_ta_n = 1'b0;
        end else begin
          wait_cnt--;
          bus_ta_n = 1'b1;
          bus_tea_n = 1'b1;
        end
      end else begin
        bus_ta_n = 1'b1;
        bus_tea_n = 1'b1;
      end
    end
  end

  task automatic cfg(input int idx, input bit en, input logic [15:0] base,
                     input logic [15:0] mask, input logic [1:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en;
    cfg_base = base; cfg_mask = mask; cfg_width = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_req(input logic [31:0] addr, input bit we, input logic [1:0] size,
                         input logic [31:0] wdata, input bit glt, input int errb, input bit poke);
    logic [1:0]  w;
    int sel, n, p, m, beats, done_beats, nbytes, to;
    logic [31:0] al, exp_rd;
    bit exp_err;
    sel = exp_sel(addr, w);
    n = sz_bytes(size);
    p = pw_bytes(w);
    m = (n < p) ? n : p;
    beats = (n > p) ? n / p : 1;
    al = addr & ~32'(n - 1);
    if (sel < 0) begin done_beats = 0; exp_err = 1'b1; end
    else if (errb >= 0 && errb < beats) begin done_beats = errb + 1; exp_err = 1'b1; end
    else begin done_beats = beats; exp_err = 1'b0; end
    exp_rd = '0;
    for (int j = 0; j < n; j++) exp_rd[(n-1-j)*8 +: 8] = mem_byte(al + 32'(j));

    ts_cnt = 0; tip_cyc = 0; lat_sum = 0; log_n = 0; oe_bad = 0; rw_bad = 0; cs_bad = 0;
    cur_beat = -1; err_beat = errb; glitch = glt; exp_read = !we; exp_p = p;
    exp_cs_pat = (sel < 0) ? 8'hFF : ~(8'(1) << sel);

    check(req_ready, "R13", "ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = addr; req_we = we; req_size = size; req_wdata = wdata;
    @(negedge clk);
    if (poke) begin
      req_addr = 32'h4000_0000; req_we = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    to = 0;
    while (!rsp_valid && to < 200) begin @(negedge clk); to++; end

    check(rsp_valid, "R11", "response seen", 32'(rsp_valid), 1);
    check(rsp_err == exp_err, (sel < 0) ? "R3" : "R12", "rsp_err", 32'(rsp_err), 32'(exp_err));
    check(ts_cnt == done_beats, "R5", "beat count", 32'(ts_cnt), 32'(done_beats));
    check(tip_cyc == lat_sum, "R11", "in-progress cycles", 32'(tip_cyc), 32'(lat_sum));
    check(bus_tip_n && (&bus_cs_n), "R9", "bus released at response", {bus_cs_n, 7'd0, bus_tip_n}, 32'h1FF);
    check(cs_bad == 0, (sel < 0) ? "R3" : "R2", "chip select", 32'(cs_bad), 0);
    check(oe_bad == 0 && rw_bad == 0, "R10", "oe/rw faults", 32'(oe_bad + rw_bad), 0);
    if (sel >= 0) begin
      int nl;
      nl = (done_beats * m < n) ? done_beats * m : n;
      check(log_n == nl, "R6", "strobed byte count", 32'(log_n), 32'(nl));
      for (int j = 0; j < nl && j < log_n; j++) begin
        check(log_a[j] == al + 32'(j), "R6", "byte lane address", log_a[j], al + 32'(j));
        if (we) check(log_d[j] == wdata[(n-1-j)*8 +: 8], "R7", "write byte",
                      32'(log_d[j]), 32'(wdata[(n-1-j)*8 +: 8]));
      end
      if (!we && !exp_err) check(rsp_rdata == exp_rd, "R8", "read data", rsp_rdata, exp_rd);
    end
    if (poke) begin
      bit extra = 1'b0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        if (rsp_valid || !bus_tip_n) extra = 1'b1;
      end
      check(!extra, "R13", "busy request ignored", 32'(extra), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd7741);
    exp_cs_pat = 8'h00; exp_read = 1'b1; exp_p = 4; err_beat = -1;
    repeat (4) @(negedge clk);
    check(bus_cs_n == 8'hFF && bus_ts_n && bus_tip_n && bus_oe_n && bus_be_n == 4'hF,
          "R1", "outputs in reset", {bus_cs_n, bus_be_n, bus_ts_n, bus_tip_n, bus_oe_n},
          {8'hFF, 4'hF, 3'b111});
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cs_n == 8'hFF && bus_tip_n && req_ready && !rsp_valid, "R1", "after reset",
          {bus_cs_n, bus_tip_n, req_ready, rsp_valid}, {8'hFF, 3'b110});

    // R2 R4: select 0 matches everything, width from strap (16-bit -> 2 beats)
    run_req(32'h7000_0002, 1'b0, 2'b10, 0, 1'b0, -1, 1'b0);

    // R4: width written for select 0 is ignored; select 4 overlaps select 1
    cfg(0, 1'b1, 16'h0000, 16'hF000, 2'b00);
    cfg(1, 1'b1, 16'h1000, 16'hF000, 2'b01);
    cfg(2, 1'b1, 16'h2000, 16'hF000, 2'b10);
    cfg(3, 1'b1, 16'h3000, 16'hF000, 2'b00);
    cfg(4, 1'b1, 16'h1000, 16'hF000, 2'b00);
    boot_phase = 1'b0;

    run_req(32'h0000_0100, 1'b1, 2'b10, 32'hA1B2C3D4, 1'b0, -1, 1'b0); // R4 still 16-bit
    run_req(32'h1000_0013, 1'b1, 2'b10, 32'h11223344, 1'b0, -1, 1'b0); // R5 R7 four beats
    run_req(32'h1000_0020, 1'b0, 2'b10, 0, 1'b0, -1, 1'b0);            // R8 on 8-bit
    run_req(32'h3000_0003, 1'b0, 2'b01, 0, 1'b0, -1, 1'b0);            // R5 misaligned half
    run_req(32'h3000_0003, 1'b1, 2'b00, 32'h0000_005A, 1'b0, -1, 1'b0); // R6 lane 0
    run_req(32'h2000_0041, 1'b0, 2'b00, 0, 1'b0, -1, 1'b0);            // R6 odd byte 16-bit
    run_req(32'h1000_0040, 1'b0, 2'b10, 0, 1'b1, -1, 1'b0);            // R11 early ack ignored
    run_req(32'h1000_0080, 1'b1, 2'b10, 32'hDEADBEEF, 1'b0, 1, 1'b0);  // R12 abort at beat 1
    run_req(32'h2000_0080, 1'b0, 2'b10, 0, 1'b0, 0, 1'b0);             // R12 first beat
    run_req(32'h4000_0000, 1'b0, 2'b10, 0, 1'b0, -1, 1'b0);            // R3 miss
    run_req(32'h2000_0100, 1'b0, 2'b10, 0, 1'b0, -1, 1'b1);            // R13 poke while busy

    for (int t = 0; t < 150; t++) begin
      logic [31:0] a;
      int eb;
      a = {4'($urandom_range(0, 4)), 28'($urandom)};
      eb = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 3)) : -1;
      run_req(a, 1'($urandom), 2'($urandom_range(0, 2)), $urandom,
              ($urandom_range(0, 5) == 0), eb, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule